// File: doc/BRIEF.md
# Burst SPI Master Register Bank

This block is the software-facing register bank of a burst SPI master. It holds two control words, four transmit data words and four receive data words behind a single-cycle memory-mapped port. The port has a byte address, write data, a write strobe and combinational read data. It passes the transfer configuration to the serial shift engine, starts that engine with a one-cycle launch pulse, and tracks completion through a small sequencer.

The sequencer has three states:
- `ST_IDLE`: no transfer is in progress.
- `ST_LAUNCH`: a single cycle in which the start pulse is raised.
- `ST_RUN`: the bank waits for the engine's done pulse.

There are three transitions:
- GO (`ST_IDLE`->`ST_LAUNCH`): taken on a bus write of 1 to the go bit.
- PROCEED (`ST_LAUNCH`->`ST_RUN`): taken when no done pulse arrives in the launch cycle.
- FINISH (`ST_LAUNCH` or `ST_RUN` -> `ST_IDLE`): taken on the done pulse.

The go bit reads as 1 whenever the state is not `ST_IDLE`, so it also serves as the busy flag. Completion sets a sticky flag, which is cleared by writing 1 to it. That flag, gated by an enable bit, drives the interrupt output. A manual select bit and a polarity bit together drive the slave-select pin.

Top module: `burst_spi_csr`

## Requirements
- R1: Register map. Word index is `bus_addr[5:2]`: 0 = control A, 1 = control B, 4..7 = receive words 0..3, 8..11 = transmit words 0..3. All other addresses, and every bit not defined below, read as 0.
  - Control A fields: RX DMA enable [0], TX DMA enable [1], interrupt enable [6], done flag [7], width [12:8], burst [14:13], lane direction [15], suspend [19:16], lane mode [21:20].
  - Control B fields: go/busy [0], select [4], polarity [5], delay [14:12], divider [31:16].
  - Transmit words read back what was written.
- R2: A write of 1 to control B bit 0 while idle starts a transfer. `xfer_start` is high for exactly the one cycle after the write. Go/busy reads 1 from that cycle until the transfer ends.
- R3: A `xfer_done` pulse while busy returns go/busy to 0 in the next cycle and sets the done flag (control A bit 7).
- R4: Writing 0 to the go bit has no effect, and `xfer_done` while idle neither sets the flag nor changes busy.
- R5: Writing 1 to control A bit 7 clears the done flag, and writing 0 leaves it. If a completion and a clearing write fall in the same cycle, the flag ends up set.
- R6: `irq` is high exactly when the done flag and the interrupt enable (control A bit 6) are both 1.
- R7: `ss_pin` is driven to the active level when select (control B bit 4) is 1, and to the inactive level otherwise. Polarity (control B bit 5) = 0 makes the active level low; polarity = 1 makes it high.
- R8: Receive words are loaded only by the engine through `rx_wr_en`/`rx_wr_idx`/`rx_wr_data`; bus writes to them are ignored.
- R9: While busy, bus writes to every register are ignored, with one exception: clearing the done flag still works.
- R10: After reset every register is 0, busy and `irq` are 0, and `ss_pin` is 1.
- R11: The configuration outputs show the current control field values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data (combinational) |
| xfer_done | input | 1 | Completion pulse from shift engine |
| rx_wr_en | input | 1 | Engine receive-word write enable |
| rx_wr_idx | input | 2 | Engine receive-word index |
| rx_wr_data | input | 32 | Engine receive-word data |
| xfer_start | output | 1 | One-cycle launch pulse |
| busy | output | 1 | Transfer in progress |
| cfg_rx_dma | output | 1 | RX DMA enable |
| cfg_tx_dma | output | 1 | TX DMA enable |
| cfg_width | output | 5 | Bit length minus one |
| cfg_burst | output | 2 | Words per transfer minus one |
| cfg_lane_dir | output | 1 | Lane direction for multi-lane modes |
| cfg_suspend | output | 4 | Suspend interval code |
| cfg_lane_mode | output | 2 | Lane mode |
| cfg_delay | output | 3 | Sample delay select |
| cfg_divider | output | 16 | Serial clock divider |
| tx_words | output | 128 | Transmit words, word 0 in the low 32 bits |
| ss_pin | output | 1 | Slave-select pin |
| irq | output | 1 | Interrupt |

## Verification
The bench goes after several corner cases:
- **Writes while busy.** A design that gated only some registers would let a transmit word or a control field change mid-transfer.
- **A completion and a flag-clearing write in the same cycle.** A design with the wrong priority would lose that completion.
- **Done pulses while idle, and writes of 0 to the go bit.** A loose design would raise a spurious flag or start a transfer.
- **Bus writes to receive words and to unmapped addresses.** A design that decoded these wrongly would corrupt received data or read back garbage.
- **All four select/polarity combinations.** Swapping their meaning would invert the pin.

// File: rtl/burst_spi_csr_pkg.sv
package burst_spi_csr_pkg;

    localparam int WORD_CTRL_A = 0;
    localparam int WORD_CTRL_B = 1;
    localparam int WORD_RX_BASE = 4;
    localparam int WORD_TX_BASE = 8;

    // Control A field positions
    localparam int A_RX_DMA = 0;
    localparam int A_TX_DMA = 1;
    localparam int A_IEN = 6;
    localparam int A_FLAG = 7;
    localparam int A_WIDTH_LO = 8;
    localparam int A_BURST_LO = 13;
    localparam int A_DIR = 15;
    localparam int A_SUSP_LO = 16;
    localparam int A_MODE_LO = 20;

    // Control B field positions
    localparam int B_GO = 0;
    localparam int B_SEL = 4;
    localparam int B_POL = 5;
    localparam int B_DLY_LO = 12;
    localparam int B_DIV_LO = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_RUN = 2'd2
    } csr_state_e;

endpackage

// File: rtl/burst_spi_csr_seq.sv
module burst_spi_csr_seq
    import burst_spi_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_wr,
    input  logic xfer_done,
    output logic busy,
    output logic xfer_start,
    output logic done_evt
);

    csr_state_e state_q;
    csr_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go_wr) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = xfer_done ? ST_IDLE : ST_RUN;
            ST_RUN: if (xfer_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else state_q <= state_d;
    end

    always_comb begin
        busy = 1'b0;
        xfer_start = 1'b0;
        done_evt = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LAUNCH: begin
                busy = 1'b1;
                xfer_start = 1'b1;
                done_evt = xfer_done;
            end
            ST_RUN: begin
                busy = 1'b1;
                done_evt = xfer_done;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/burst_spi_csr_ctrl.sv
module burst_spi_csr_ctrl
    import burst_spi_csr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WIDTH_W = 5,
    parameter int BURST_W = 2,
    parameter int SUSP_W = 4,
    parameter int MODE_W = 2,
    parameter int DLY_W = 3,
    parameter int DIV_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_a,
    input  logic wr_b,
    input  logic [DATA_W-1:0] wdata,
    input  logic busy,
    input  logic done_evt,
    output logic rx_dma,
    output logic tx_dma,
    output logic ien,
    output logic flag,
    output logic [WIDTH_W-1:0] width,
    output logic [BURST_W-1:0] burst,
    output logic lane_dir,
    output logic [SUSP_W-1:0] suspend,
    output logic [MODE_W-1:0] lane_mode,
    output logic sel,
    output logic pol,
    output logic [DLY_W-1:0] delay,
    output logic [DIV_W-1:0] divider
);

    logic upd_a;
    logic upd_b;
    logic unused_bits;

    assign upd_a = wr_a && !busy;
    assign upd_b = wr_b && !busy;
    assign unused_bits = ^wdata[3:2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_dma <= 1'b0;
            tx_dma <= 1'b0;
            ien <= 1'b0;
            width <= '0;
            burst <= '0;
            lane_dir <= 1'b0;
            suspend <= '0;
            lane_mode <= '0;
        end else if (upd_a) begin
            rx_dma <= wdata[A_RX_DMA];
            tx_dma <= wdata[A_TX_DMA];
            ien <= wdata[A_IEN];
            width <= wdata[A_WIDTH_LO +: WIDTH_W];
            burst <= wdata[A_BURST_LO +: BURST_W];
            lane_dir <= wdata[A_DIR];
            suspend <= wdata[A_SUSP_LO +: SUSP_W];
            lane_mode <= wdata[A_MODE_LO +: MODE_W];
        end
    end

    // Completion outranks a clearing write in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag <= 1'b0;
        else if (done_evt) flag <= 1'b1;
        else if (wr_a && wdata[A_FLAG]) flag <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel <= 1'b0;
            pol <= 1'b0;
            delay <= '0;
            divider <= '0;
        end else if (upd_b) begin
            sel <= wdata[B_SEL];
            pol <= wdata[B_POL];
            delay <= wdata[B_DLY_LO +: DLY_W];
            divider <= wdata[B_DIV_LO +: DIV_W];
        end
    end

endmodule

// File: rtl/burst_spi_csr_data.sv
module burst_spi_csr_data #(
    parameter int DATA_W = 32,
    parameter int NUM_WORDS = 4,
    localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_wr,
    input  logic [IDX_W-1:0] tx_idx,
    input  logic [DATA_W-1:0] tx_data,
    input  logic rx_wr,
    input  logic [IDX_W-1:0] rx_idx,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [DATA_W-1:0] tx_rd,
    output logic [DATA_W-1:0] rx_rd,
    output logic [NUM_WORDS*DATA_W-1:0] tx_flat
);

    logic [DATA_W-1:0] tx_q [NUM_WORDS];
    logic [DATA_W-1:0] rx_q [NUM_WORDS];

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tx_q[i] <= '0;
            else if (tx_wr && tx_idx == IDX_W'(i)) tx_q[i] <= tx_data;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rx_q[i] <= '0;
            else if (rx_wr && rx_idx == IDX_W'(i)) rx_q[i] <= rx_data;
        end
        assign tx_flat[i*DATA_W +: DATA_W] = tx_q[i];
    end

    assign tx_rd = tx_q[rd_idx];
    assign rx_rd = rx_q[rd_idx];

endmodule

// File: rtl/burst_spi_csr.sv
module burst_spi_csr
    import burst_spi_csr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int NUM_WORDS = 4,
    localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int WORD_AW = ADDR_W - 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic xfer_done,
    input  logic rx_wr_en,
    input  logic [IDX_W-1:0] rx_wr_idx,
    input  logic [DATA_W-1:0] rx_wr_data,
    output logic xfer_start,
    output logic busy,
    output logic cfg_rx_dma,
    output logic cfg_tx_dma,
    output logic [4:0] cfg_width,
    output logic [1:0] cfg_burst,
    output logic cfg_lane_dir,
    output logic [3:0] cfg_suspend,
    output logic [1:0] cfg_lane_mode,
    output logic [2:0] cfg_delay,
    output logic [15:0] cfg_divider,
    output logic [NUM_WORDS*DATA_W-1:0] tx_words,
    output logic ss_pin,
    output logic irq
);

    logic [WORD_AW-1:0] word;
    logic hit_a;
    logic hit_b;
    logic hit_rx;
    logic hit_tx;
    logic [IDX_W-1:0] sub_idx;
    logic done_evt;
    logic flag;
    logic ien;
    logic sel;
    logic pol;
    logic [DATA_W-1:0] tx_rd;
    logic [DATA_W-1:0] rx_rd;
    logic unused_addr;

    assign word = bus_addr[ADDR_W-1:2];
    assign unused_addr = ^bus_addr[1:0];

    always_comb begin
        hit_a = (32'(word) == WORD_CTRL_A);
        hit_b = (32'(word) == WORD_CTRL_B);
        hit_rx = (32'(word) >= WORD_RX_BASE) && (32'(word) < WORD_RX_BASE + NUM_WORDS);
        hit_tx = (32'(word) >= WORD_TX_BASE) && (32'(word) < WORD_TX_BASE + NUM_WORDS);
        sub_idx = hit_tx ? IDX_W'(32'(word) - WORD_TX_BASE) : IDX_W'(32'(word) - WORD_RX_BASE);
    end

    burst_spi_csr_seq u_seq (
        .clk(clk),
        .rst_n(rst_n),
        .go_wr(bus_we && hit_b && bus_wdata[B_GO]),
        .xfer_done(xfer_done),
        .busy(busy),
        .xfer_start(xfer_start),
        .done_evt(done_evt)
    );

    burst_spi_csr_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk(clk),
        .rst_n(rst_n),
        .wr_a(bus_we && hit_a),
        .wr_b(bus_we && hit_b),
        .wdata(bus_wdata),
        .busy(busy),
        .done_evt(done_evt),
        .rx_dma(cfg_rx_dma),
        .tx_dma(cfg_tx_dma),
        .ien(ien),
        .flag(flag),
        .width(cfg_width),
        .burst(cfg_burst),
        .lane_dir(cfg_lane_dir),
        .suspend(cfg_suspend),
        .lane_mode(cfg_lane_mode),
        .sel(sel),
        .pol(pol),
        .delay(cfg_delay),
        .divider(cfg_divider)
    );

    burst_spi_csr_data #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS)) u_data (
        .clk(clk),
        .rst_n(rst_n),
        .tx_wr(bus_we && hit_tx && !busy),
        .tx_idx(sub_idx),
        .tx_data(bus_wdata),
        .rx_wr(rx_wr_en),
        .rx_idx(rx_wr_idx),
        .rx_data(rx_wr_data),
        .rd_idx(sub_idx),
        .tx_rd(tx_rd),
        .rx_rd(rx_rd),
        .tx_flat(tx_words)
    );

    always_comb begin
        bus_rdata = '0;
        if (hit_a) begin
            bus_rdata[A_RX_DMA] = cfg_rx_dma;
            bus_rdata[A_TX_DMA] = cfg_tx_dma;
            bus_rdata[A_IEN] = ien;
            bus_rdata[A_FLAG] = flag;
            bus_rdata[A_WIDTH_LO +: 5] = cfg_width;
            bus_rdata[A_BURST_LO +: 2] = cfg_burst;
            bus_rdata[A_DIR] = cfg_lane_dir;
            bus_rdata[A_SUSP_LO +: 4] = cfg_suspend;
            bus_rdata[A_MODE_LO +: 2] = cfg_lane_mode;
        end else if (hit_b) begin
            bus_rdata[B_GO] = busy;
            bus_rdata[B_SEL] = sel;
            bus_rdata[B_POL] = pol;
            bus_rdata[B_DLY_LO +: 3] = cfg_delay;
            bus_rdata[B_DIV_LO +: 16] = cfg_divider;
        end else if (hit_rx) begin
            bus_rdata = rx_rd;
        end else if (hit_tx) begin
            bus_rdata = tx_rd;
        end
    end

    assign ss_pin = pol ? sel : !sel;
    assign irq = flag && ien;

endmodule

// File: rtl/burst_spi_csr_chk.sv
module burst_spi_csr_chk #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int TXW = 128
) (
    input logic clk,
    input logic rst_n,
    input logic bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic busy,
    input logic xfer_start,
    input logic xfer_done,
    input logic flag,
    input logic ss_pin,
    input logic [TXW-1:0] tx_words
);

    logic go_write;
    logic wr_b;
    logic clr_write;

    assign wr_b = bus_we && (32'(bus_addr[ADDR_W-1:2]) == 1);
    assign go_write = wr_b && bus_wdata[0];
    assign clr_write = bus_we && (32'(bus_addr[ADDR_W-1:2]) == 0) && bus_wdata[7];

    assert_go_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (go_write && !busy) |=> (busy && xfer_start));
    assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);
    assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !xfer_done) |=> busy);
    assert_done_finish_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && xfer_done) |=> (!busy && flag));
    assert_no_spurious_go_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !go_write) |=> !busy);
    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_write) |=> flag);
    assert_ss_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_b |=> $stable(ss_pin));
    assert_tx_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(tx_words));

endmodule

bind burst_spi_csr burst_spi_csr_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .TXW(NUM_WORDS*DATA_W)
) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .bus_we(bus_we),
    .bus_addr(bus_addr),
    .bus_wdata(bus_wdata),
    .busy(busy),
    .xfer_start(xfer_start),
    .xfer_done(xfer_done),
    .flag(flag),
    .ss_pin(ss_pin),
    .tx_words(tx_words)
);

// File: tb/sim_burst_spi_csr.sv
module sim_burst_spi_csr;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic xfer_done = 1'b0;
    logic rx_wr_en = 1'b0;
    logic [1:0] rx_wr_idx = '0;
    logic [31:0] rx_wr_data = '0;
    logic xfer_start, busy, cfg_rx_dma, cfg_tx_dma, cfg_lane_dir, ss_pin, irq;
    logic [4:0] cfg_width;
    logic [1:0] cfg_burst, cfg_lane_mode;
    logic [3:0] cfg_suspend;
    logic [2:0] cfg_delay;
    logic [15:0] cfg_divider;
    logic [127:0] tx_words;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = !clk;

    burst_spi_csr u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .xfer_done(xfer_done),
        .rx_wr_en(rx_wr_en), .rx_wr_idx(rx_wr_idx), .rx_wr_data(rx_wr_data),
        .xfer_start(xfer_start), .busy(busy), .cfg_rx_dma(cfg_rx_dma),
        .cfg_tx_dma(cfg_tx_dma), .cfg_width(cfg_width), .cfg_burst(cfg_burst),
        .cfg_lane_dir(cfg_lane_dir), .cfg_suspend(cfg_suspend),
        .cfg_lane_mode(cfg_lane_mode), .cfg_delay(cfg_delay),
        .cfg_divider(cfg_divider), .tx_words(tx_words), .ss_pin(ss_pin), .irq(irq)
    );

    // Register-map vectors: write address, write data, expected read-back (R1, R8)
    localparam int NV = 10;
    localparam logic [5:0] V_ADDR [NV] = '{6'h00, 6'h00, 6'h04, 6'h04, 6'h20,
                                          6'h24, 6'h28, 6'h2C, 6'h3C, 6'h10};
    localparam logic [31:0] V_WDATA [NV] = '{32'hFFFFFFFF, 32'h12345678, 32'hFFFFFFFE,
                                            32'hA5A50010, 32'hDEADBEEF, 32'h01234567,
                                            32'h89ABCDEF, 32'hCAFEF00D, 32'hFFFFFFFF,
                                            32'hFFFFFFFF};
    localparam logic [31:0] V_EXP [NV] = '{32'h003FFF43, 32'h00345640, 32'hFFFF7030,
                                          32'hA5A50010, 32'hDEADBEEF, 32'h01234567,
                                          32'h89ABCDEF, 32'hCAFEF00D, 32'h00000000,
                                          32'h00000000};

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(bus_rdata, exp, tag);
    endtask

    task automatic pulse_done();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        rd(6'h00, 32'h0, "R10 ctrl A reset");
        rd(6'h04, 32'h0, "R10 ctrl B reset");
        chk({31'b0, ss_pin}, 32'h1, "R10 ss_pin reset");
        chk({30'b0, busy, irq}, 32'h0, "R10 busy/irq reset");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            wr(V_ADDR[i], V_WDATA[i]);
            rd(V_ADDR[i], V_EXP[i], $sformatf("R1 vector %0d", i));
        end

        // R11: configuration outputs mirror fields
        chk({27'b0, cfg_width}, 32'h16, "R11 width");
        chk({30'b0, cfg_burst}, 32'h2, "R11 burst");
        chk({28'b0, cfg_suspend}, 32'h4, "R11 suspend");
        chk({30'b0, cfg_lane_mode}, 32'h3, "R11 lane mode");
        chk({16'b0, cfg_divider}, 32'hA5A5, "R11 divider");
        chk({29'b0, cfg_delay}, 32'h0, "R11 delay");
        chk(tx_words[31:0], 32'hDEADBEEF, "R11 tx word 0");
        chk(tx_words[127:96], 32'hCAFEF00D, "R11 tx word 3");
        chk({31'b0, ss_pin}, 32'h0, "R7 select=1 pol=0");

        // R2: launch
        wr(6'h04, 32'hA5A50011);
        chk({31'b0, xfer_start}, 32'h1, "R2 start pulse");
        rd(6'h04, 32'hA5A50011, "R2 go reads 1");
        @(negedge clk);
        chk({31'b0, xfer_start}, 32'h0, "R2 start single");
        chk({31'b0, busy}, 32'h1, "R2 busy holds");

        // R9: writes while busy ignored
        wr(6'h20, 32'h11111111);
        rd(6'h20, 32'hDEADBEEF, "R9 tx frozen");
        wr(6'h00, 32'h00000000);
        rd(6'h00, 32'h00345640, "R9 ctrl A frozen");
        wr(6'h04, 32'h00000000);
        chk({31'b0, ss_pin}, 32'h0, "R9 ss frozen");

        // R3, R6: completion
        pulse_done();
        chk({31'b0, busy}, 32'h0, "R3 busy clears");
        rd(6'h00, 32'h003456C0, "R3 flag set");
        chk({31'b0, irq}, 32'h1, "R6 irq high");

        // R5 and R6
        wr(6'h00, 32'h00345640);
        rd(6'h00, 32'h003456C0, "R5 write 0 keeps flag");
        wr(6'h00, 32'h00345600);
        chk({31'b0, irq}, 32'h0, "R6 irq gated by enable");
        rd(6'h00, 32'h00345680, "R6 flag kept with ien=0");
        wr(6'h00, 32'h003456C0);
        rd(6'h00, 32'h00345640, "R5 write 1 clears");
        chk({31'b0, irq}, 32'h0, "R6 irq low after clear");

        // R4: stray done and go=0
        pulse_done();
        rd(6'h00, 32'h00345640, "R4 idle done ignored");
        wr(6'h04, 32'hA5A50010);
        chk({30'b0, busy, xfer_start}, 32'h0, "R4 go=0 no start");
        @(negedge clk);
        chk({31'b0, busy}, 32'h0, "R4 stays idle");

        // R5: completion wins over clearing write
        wr(6'h04, 32'hA5A50011);
        @(negedge clk);
        xfer_done = 1'b1;
        bus_we = 1'b1;
        bus_addr = 6'h00;
        bus_wdata = 32'h003456C0;
        @(negedge clk);
        xfer_done = 1'b0;
        bus_we = 1'b0;
        rd(6'h00, 32'h003456C0, "R5 set wins");
        chk({31'b0, busy}, 32'h0, "R3 done after launch");

        // R8: engine writes receive words, bus cannot
        @(negedge clk);
        rx_wr_en = 1'b1;
        rx_wr_idx = 2'd2;
        rx_wr_data = 32'h55AA55AA;
        @(negedge clk);
        rx_wr_en = 1'b0;
        rd(6'h18, 32'h55AA55AA, "R8 engine load");
        wr(6'h18, 32'h0);
        rd(6'h18, 32'h55AA55AA, "R8 bus write ignored");

        // R7: polarity combinations
        wr(6'h04, 32'hA5A50000);
        chk({31'b0, ss_pin}, 32'h1, "R7 sel0 pol0");
        wr(6'h04, 32'hA5A50020);
        chk({31'b0, ss_pin}, 32'h0, "R7 sel0 pol1");
        wr(6'h04, 32'hA5A50030);
        chk({31'b0, ss_pin}, 32'h1, "R7 sel1 pol1");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule